// File: doc/BRIEF.md
# Power register access command engine

This block sits behind a host-to-controller mailbox and carries out register access commands on a byte-wide register port. When the mailbox has latched a command word and its 16-byte outgoing payload, it pulses `start_i`. The engine checks the command, takes the packed register addresses and data bytes out of the payload, and performs the accesses one after another. It then reports completion with a one-cycle `done_o` and an error code.

Three operations are supported: a register write, a register read, and a masked read-modify-write. Read results are gathered into a 16-byte return buffer that the mailbox exposes to the host. The register port is a plain request interface. A read returns its byte a fixed number of cycles after the request. A write takes effect in the cycle of its request.

Top module: `regcmd_engine`

## Requirements
- R1: Only command code 0xFF in command word bits [7:0] is executed. Any other code ends with `err_code_o` = 1, `err_o` high and no register access.
- R2: The sub-id in command word bits [15:12] selects the operation: 0 write, 1 read, 2 read-modify-write. Any other sub-id ends with `err_code_o` = 2 and no access.
- R3: Register address k is the 16-bit little-endian value in payload bytes 2k (low byte) and 2k+1 (high byte), where payload byte j is `wbuf_i[8j+7:8j]`.
- R4: A read of N registers has size field (bits [23:16]) 2N. The byte read from address k is placed in return buffer byte k for k < N, and return buffer bytes N and above read as zero.
- R5: A write of N registers has size field 3N. The data byte for address k is payload byte 2N+k.
- R6: A read-modify-write has size field 4. It reads the address in bytes 0..1, then writes back (old & ~mask) | (value & mask), where value is byte 2 and mask is byte 3.
- R7: A register count of zero, a count above MAX_REGS (5), or a size that does not match the operation ends with `err_code_o` = 3 and no access.
- R8: Accesses are issued in address-list order, one at a time. After a read request, no further request is made until RD_LAT+1 cycles later.
- R9: `done_o` is high for exactly one cycle per accepted command, after the last access. `err_o` and `err_code_o` are valid with `done_o` and are held until the next accepted start.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: Write, read-modify-write and rejected commands leave the return buffer unchanged.
- R12: After reset, `busy_o`, `done_o`, `err_o` and `rf_req_o` are low, and `err_code_o` and `rbuf_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Execute the command presented on cmd_i and wbuf_i |
| cmd_i | input | 32 | Command word: code [7:0], sub-id [15:12], size [23:16] |
| wbuf_i | input | 128 | Outgoing payload, byte j at bits [8j+7:8j] |
| rf_req_o | output | 1 | Register port request |
| rf_we_o | output | 1 | Request is a write |
| rf_addr_o | output | 16 | Register address |
| rf_wdata_o | output | 8 | Write data |
| rf_rdata_i | input | 8 | Read data, valid RD_LAT cycles after a read request |
| rbuf_o | output | 128 | Return buffer, byte j at bits [8j+7:8j] |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command failed |
| err_code_o | output | 8 | 0 ok, 1 bad code, 2 bad sub-id, 3 bad size or count |

## Verification
The bench builds the engine with MAX_REGS at 5 and RD_LAT at 3. A latency above one makes a read that is sampled a cycle early or late pick up a poison byte from the bench's register model. It also makes the spacing after each read long enough to measure. With five registers per command, both the largest write payload (15 of 16 bytes) and a full-length read that leaves the upper return bytes zero are reachable. The long read also gives a window in which a second start can be driven while the engine is busy.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam logic [7:0] CMD_REGACC = 8'hFF;
  localparam int F_CODE = 0;
  localparam int F_SUB  = 12;
  localparam int F_SIZE = 16;

  localparam logic [7:0] E_NONE = 8'd0;
  localparam logic [7:0] E_CODE = 8'd1;
  localparam logic [7:0] E_SUB  = 8'd2;
  localparam logic [7:0] E_SIZE = 8'd3;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_RMW = 2'd2} op_e;
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_RMWW, S_FIN} st_e;
endpackage

// File: rtl/regcmd_decode.sv
module regcmd_decode
  import regcmd_pkg::*;
#(
  parameter int MAX_REGS = 5,
  parameter int CNT_W    = 3
) (
  input  logic [31:0]      cmd_i,
  output op_e              op_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       err_o
);
  localparam logic [7:0] MAX8 = 8'(MAX_REGS);

  logic [7:0] code, sz, sz_div3;
  logic [3:0] sub;

  assign code    = cmd_i[F_CODE +: 8];
  assign sub     = cmd_i[F_SUB +: 4];
  assign sz      = cmd_i[F_SIZE +: 8];
  assign sz_div3 = sz / 8'd3;

  always_comb begin
    op_o  = OP_WR;
    cnt_o = '0;
    err_o = E_NONE;
    if (code != CMD_REGACC) begin
      err_o = E_CODE;
    end else begin
      case (sub)
        4'd0: begin
          op_o = OP_WR;
          if (sz == 8'd0 || (sz % 8'd3) != 8'd0 || sz_div3 > MAX8) err_o = E_SIZE;
          else cnt_o = CNT_W'(sz_div3);
        end
        4'd1: begin
          op_o = OP_RD;
          if (sz == 8'd0 || sz[0] || (sz >> 1) > MAX8) err_o = E_SIZE;
          else cnt_o = CNT_W'(sz >> 1);
        end
        4'd2: begin
          op_o = OP_RMW;
          if (sz != 8'd4) err_o = E_SIZE;
          else cnt_o = CNT_W'(1);
        end
        default: err_o = E_SUB;
      endcase
    end
  end

  // R7: an accepted command always carries a count in range
  always_comb begin
    if (!$isunknown(cmd_i) && err_o == E_NONE)
      a_cnt_range_r7: assert (cnt_o != '0 && cnt_o <= CNT_W'(MAX_REGS));
  end
endmodule

// File: rtl/regcmd_rbuf.sv
module regcmd_rbuf #(
  parameter int NBYTES = 16,
  parameter int IDX_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [7:0]          data_i,
  output logic [NBYTES*8-1:0] rbuf_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   rbuf_o[8*b +: 8] <= '0;
      else if (clr_i)                                rbuf_o[8*b +: 8] <= '0;
      else if (we_i && 32'(idx_i) == b)              rbuf_o[8*b +: 8] <= data_i;
    end
  end
endmodule

// File: rtl/regcmd_seq.sv
module regcmd_seq
  import regcmd_pkg::*;
#(
  parameter int WBUF_BYTES = 16,
  parameter int RD_LAT     = 2,
  parameter int CNT_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [WBUF_BYTES*8-1:0] wbuf_i,
  input  op_e                     dec_op_i,
  input  logic [CNT_W-1:0]        dec_cnt_i,
  input  logic [7:0]              dec_err_i,
  output logic                    rf_req_o,
  output logic                    rf_we_o,
  output logic [15:0]             rf_addr_o,
  output logic [7:0]              rf_wdata_o,
  input  logic [7:0]              rf_rdata_i,
  output logic                    rb_clr_o,
  output logic                    rb_we_o,
  output logic [CNT_W-1:0]        rb_idx_o,
  output logic [7:0]              rb_data_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [7:0]              err_code_o
);
  localparam int LAT_W = $clog2(RD_LAT + 1);
  localparam int SEL_W = $clog2(WBUF_BYTES);

  st_e                     state_q;
  op_e                     op_q;
  logic [CNT_W-1:0]        idx_q, cnt_q;
  logic [LAT_W-1:0]        lat_q;
  logic [WBUF_BYTES*8-1:0] wbuf_q;
  logic [7:0]              wd_q;
  logic                    accept, last, rd_back;
  logic [SEL_W-1:0]        wsel;
  logic [7:0]              rmw_val, rmw_mask;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign last     = (idx_q == cnt_q - CNT_W'(1));
  assign rd_back  = (state_q == S_WAIT) && (lat_q == LAT_W'(RD_LAT));
  assign wsel     = SEL_W'({cnt_q, 1'b0}) + SEL_W'(idx_q);
  assign rmw_val  = wbuf_q[16 +: 8];
  assign rmw_mask = wbuf_q[24 +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= OP_WR;
      idx_q      <= '0;
      cnt_q      <= '0;
      lat_q      <= '0;
      wbuf_q     <= '0;
      wd_q       <= '0;
      err_code_o <= E_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          wbuf_q     <= wbuf_i;
          op_q       <= dec_op_i;
          cnt_q      <= dec_cnt_i;
          idx_q      <= '0;
          err_code_o <= dec_err_i;
          state_q    <= (dec_err_i != E_NONE) ? S_FIN : S_ISSUE;
        end
        S_ISSUE: begin
          if (op_q == OP_WR) begin
            if (last) state_q <= S_FIN;
            else      idx_q   <= idx_q + CNT_W'(1);
          end else begin
            lat_q   <= LAT_W'(1);
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rd_back) begin
            if (op_q == OP_RMW) begin
              wd_q    <= (rf_rdata_i & ~rmw_mask) | (rmw_val & rmw_mask);
              state_q <= S_RMWW;
            end else if (last) begin
              state_q <= S_FIN;
            end else begin
              idx_q   <= idx_q + CNT_W'(1);
              state_q <= S_ISSUE;
            end
          end else begin
            lat_q <= lat_q + LAT_W'(1);
          end
        end
        S_RMWW:  state_q <= S_FIN;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_req_o   = (state_q == S_ISSUE) || (state_q == S_RMWW);
    rf_we_o    = ((state_q == S_ISSUE) && (op_q == OP_WR)) || (state_q == S_RMWW);
    rf_addr_o  = wbuf_q[{idx_q, 4'b0000} +: 16];
    rf_wdata_o = '0;
    if (state_q == S_RMWW)                           rf_wdata_o = wd_q;
    else if (state_q == S_ISSUE && op_q == OP_WR)    rf_wdata_o = wbuf_q[{wsel, 3'b000} +: 8];
  end

  assign rb_clr_o  = accept && (dec_err_i == E_NONE) && (dec_op_i == OP_RD);
  assign rb_we_o   = rd_back && (op_q == OP_RD);
  assign rb_idx_o  = idx_q;
  assign rb_data_o = rf_rdata_i;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_FIN);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_read_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && !rf_we_o) |=> !rf_req_o);
  p_reject_no_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_err_i != E_NONE) |=> (done_o && !rf_req_o));
  p_req_in_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_o |-> (busy_o && !done_o));
  p_busy_ignores_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
  import regcmd_pkg::*;
#(
  parameter int MAX_REGS   = 5,
  parameter int WBUF_BYTES = 16,
  parameter int RBUF_BYTES = 16,
  parameter int RD_LAT     = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [31:0]             cmd_i,
  input  logic [WBUF_BYTES*8-1:0] wbuf_i,
  output logic                    rf_req_o,
  output logic                    rf_we_o,
  output logic [15:0]             rf_addr_o,
  output logic [7:0]              rf_wdata_o,
  input  logic [7:0]              rf_rdata_i,
  output logic [RBUF_BYTES*8-1:0] rbuf_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic [7:0]              err_code_o
);
  localparam int CNT_W = $clog2(MAX_REGS + 1);

  op_e              dec_op;
  logic [CNT_W-1:0] dec_cnt, rb_idx;
  logic [7:0]       dec_err, rb_data;
  logic             rb_clr, rb_we;

  regcmd_decode #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W)) u_decode (
    .cmd_i(cmd_i), .op_o(dec_op), .cnt_o(dec_cnt), .err_o(dec_err)
  );

  regcmd_seq #(.WBUF_BYTES(WBUF_BYTES), .RD_LAT(RD_LAT), .CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wbuf_i(wbuf_i),
    .dec_op_i(dec_op), .dec_cnt_i(dec_cnt), .dec_err_i(dec_err),
    .rf_req_o(rf_req_o), .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o),
    .rf_wdata_o(rf_wdata_o), .rf_rdata_i(rf_rdata_i),
    .rb_clr_o(rb_clr), .rb_we_o(rb_we), .rb_idx_o(rb_idx), .rb_data_o(rb_data),
    .busy_o(busy_o), .done_o(done_o), .err_code_o(err_code_o)
  );

  regcmd_rbuf #(.NBYTES(RBUF_BYTES), .IDX_W(CNT_W)) u_rbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rb_clr), .we_i(rb_we),
    .idx_i(rb_idx), .data_i(rb_data), .rbuf_o(rbuf_o)
  );

  assign err_o = (err_code_o != E_NONE);
endmodule

// File: tb/regcmd_engine_tb.sv
module regcmd_engine_tb;
  localparam int RD_LAT = 3;
  localparam int NV     = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  cmd = '0;
  logic [127:0] wbuf = '0;
  logic         rf_req, rf_we, busy, done, err;
  logic [15:0]  rf_addr;
  logic [7:0]   rf_wdata, rf_rdata, err_code;
  logic [127:0] rbuf;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  regcmd_engine #(.MAX_REGS(5), .WBUF_BYTES(16), .RBUF_BYTES(16), .RD_LAT(RD_LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .wbuf_i(wbuf),
    .rf_req_o(rf_req), .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata),
    .rf_rdata_i(rf_rdata), .rbuf_o(rbuf), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(err_code)
  );

  // behavioural register file with access log
  logic [7:0]  mem [256];
  logic [7:0]  pipe [RD_LAT];
  logic [15:0] log_a [64];
  logic        log_w [64];
  logic [7:0]  log_d [64];
  int          log_n = 0;
  int          cyc = 0;
  int          last_rd = 0;
  bit          rd_pend = 0;
  int          gap_err = 0;

  assign rf_rdata = pipe[RD_LAT-1];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      for (int i = 0; i < RD_LAT; i++) pipe[i] <= 8'hEE;
    end else begin
      if (rf_req && rf_we) mem[rf_addr[7:0]] <= rf_wdata ^ rf_addr[15:8];
      pipe[0] <= (rf_req && !rf_we) ? (mem[rf_addr[7:0]] ^ rf_addr[15:8]) : 8'hEE;
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
      if (rf_req) begin
        log_a[log_n % 64] <= rf_addr;
        log_w[log_n % 64] <= rf_we;
        log_d[log_n % 64] <= rf_wdata;
        log_n <= log_n + 1;
        if (rd_pend && cyc < last_rd + RD_LAT + 1) gap_err <= gap_err + 1;
        if (!rf_we) begin
          last_rd <= cyc;
          rd_pend <= 1'b1;
        end
      end
    end
  end

  // shadow model
  logic [7:0]   sm [256];
  logic [127:0] exp_rbuf = '0;

  function automatic logic [7:0] sm_rd(input logic [15:0] a);
    return sm[a[7:0]] ^ a[15:8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {expected error code, command word, payload}
  localparam logic [167:0] VEC [NV] = '{
    {8'd0, 32'h000600FF, 128'h00000000_00000000_00005CA5_34111210},
    {8'd0, 32'h000A10FF, 128'h00000000_00000000_0009FF08_00073411_1210},
    {8'd0, 32'h000420FF, 128'h00000000_00000000_00000000_3CF01210},
    {8'd0, 32'h000210FF, 128'h00000000_00000000_00000000_00001210},
    {8'd0, 32'h000F00FF, 128'h00554433_22110104_01030102_01010100},
    {8'd1, 32'h000210FE, 128'h00000000_00000000_00000000_00001210},
    {8'd2, 32'h000230FF, 128'h00000000_00000000_00000000_00001210},
    {8'd3, 32'h000010FF, 128'h00000000_00000000_00000000_00001210},
    {8'd3, 32'h000C10FF, 128'h00000000_00000000_00000000_00001210},
    {8'd3, 32'h000400FF, 128'h00000000_00000000_00000000_00001210},
    {8'd3, 32'h000320FF, 128'h00000000_00000000_00000000_00001210},
    {8'd3, 32'h000310FF, 128'h00000000_00000000_00000000_00001210},
    {8'd0, 32'h000410FF, 128'h00000000_00000000_00000000_00010101}
  };

  task automatic run_cmd(input logic [31:0] c, input logic [127:0] w,
                         input logic [7:0] exp_code, input bit poke);
    logic [15:0] ea [8];
    logic        ew [8];
    logic [7:0]  ed [8];
    int          en = 0;
    int          n;
    int          start_log;
    int          ndone = 0;
    logic [7:0]  g_code = '0;
    logic        g_err = 1'b0;
    logic [127:0] g_rbuf = '0;
    logic [7:0]  sz = c[23:16];
    logic [3:0]  sub = c[15:12];
    logic [7:0]  old, nv;
    string       tag;
    // reference
    if (exp_code == 8'd1)      tag = "R1";
    else if (exp_code == 8'd2) tag = "R2";
    else if (exp_code == 8'd3) tag = "R7";
    else if (sub == 4'd1)      tag = "R4";
    else if (sub == 4'd0)      tag = "R5";
    else                       tag = "R6";
    if (exp_code == 8'd0) begin
      if (sub == 4'd1) begin
        n = int'(sz) / 2;
        exp_rbuf = '0;
        for (int k = 0; k < n; k++) begin
          ea[en] = w[16*k +: 16]; ew[en] = 1'b0; ed[en] = '0; en++;
          exp_rbuf[8*k +: 8] = sm_rd(w[16*k +: 16]);
        end
      end else if (sub == 4'd0) begin
        n = int'(sz) / 3;
        for (int k = 0; k < n; k++) begin
          ea[en] = w[16*k +: 16]; ew[en] = 1'b1; ed[en] = w[8*(2*n+k) +: 8]; en++;
          sm[w[16*k +: 8]] = w[8*(2*n+k) +: 8] ^ w[16*k+8 +: 8];
        end
      end else begin
        old = sm_rd(w[15:0]);
        nv  = (old & ~w[31:24]) | (w[23:16] & w[31:24]);
        ea[0] = w[15:0]; ew[0] = 1'b0; ed[0] = '0;
        ea[1] = w[15:0]; ew[1] = 1'b1; ed[1] = nv;
        en = 2;
        sm[w[7:0]] = nv ^ w[15:8];
      end
    end
    start_log = log_n;
    @(negedge clk);
    start = 1'b1; cmd = c; wbuf = w;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (poke && k == 1) begin
        start = 1'b1; cmd = 32'h000300FF; wbuf = 128'hEE0007;
      end
      if (poke && k == 2) start = 1'b0;
      if (done) begin
        ndone++;
        g_code = err_code; g_err = err; g_rbuf = rbuf;
      end
    end
    chk(ndone == 1, "R9", 128'(ndone), 128'd1);
    chk(g_code == exp_code, tag, 128'(g_code), 128'(exp_code));
    chk(g_err == (exp_code != 0), tag, 128'(g_err), 128'(exp_code != 0));
    chk(err_code == exp_code, "R9", 128'(err_code), 128'(exp_code));
    chk(g_rbuf == exp_rbuf, (sub == 4'd1 && exp_code == 0) ? "R4" : "R11", g_rbuf, exp_rbuf);
    chk(log_n - start_log == en, poke ? "R10" : tag, 128'(log_n - start_log), 128'(en));
    for (int k = 0; k < en && k < log_n - start_log; k++) begin
      int s = (start_log + k) % 64;
      chk(log_a[s] == ea[k] && log_w[s] == ew[k] && (!ew[k] || log_d[s] == ed[k]),
          "R3", {log_a[s], 7'd0, log_w[s], log_d[s]}, {ea[k], 7'd0, ew[k], ed[k]});
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sm[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !err && !rf_req, "R12", {busy, done, err, rf_req}, 128'd0);
    chk(err_code == 0 && rbuf == 0, "R12", rbuf, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_cmd(VEC[v][159:128], VEC[v][127:0], VEC[v][167:160], 1'b0);
    // R10: second start during a 5-register read is dropped
    run_cmd(VEC[1][159:128], VEC[1][127:0], 8'd0, 1'b1);
    run_cmd(32'h000210FF, 128'h0007, 8'd0, 1'b0);
    // R8: read spacing
    chk(gap_err == 0, "R8", 128'(gap_err), 128'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule